// File: doc/BRIEF.md
# Credit-counter dual-clock FIFO

This block moves fixed-width words from a write clock domain to an unrelated read clock domain. The words sit in a small register array clocked by the writer. Each side keeps its own occupancy counter. The write side counts the slots it may still fill, and the read side counts the words it may take. Both counters are registered in their own domain and are shown to the user next to a full flag or an empty flag.

An accepted write lowers the write-side counter at its own clock edge. The same write also flips a toggle, which a two-stage synchronizer carries into the read domain. There an edge detector turns the change back into a one-cycle pulse, and that pulse adds one credit to the read-side counter. Reads follow the mirror path back to the writer. Because the returning credit always lags, the flags are pessimistic but never unsafe.

The read port is first-word fall-through: the oldest word is on the output whenever the FIFO is not empty. A read strobe retires that word. Strobes are single-cycle pulses. On each side they must be spaced at least two clock periods of the other domain apart, so the sustained rate is half of the slower clock.

Top module: `credit_xclk_fifo`

## Requirements
- R1: When reset is asserted, the write-side free count equals DEPTH with full low, and the read-side available count is 0 with empty high.
- R2: A write strobe taken while full is low lowers the free count by one at that write clock edge. One credit then reaches the available count within three read clock edges and no sooner than the third.
- R3: A read strobe taken while empty is low lowers the available count by one at that read clock edge. One credit then reaches the free count within three write clock edges and no sooner than the third.
- R4: Full is high exactly when the free count is 0. It goes high in the write cycle right after the edge that consumed the last free slot.
- R5: Empty is high exactly when the available count is 0. It goes high in the read cycle right after the edge that retired the last available word.
- R6: A write strobe while full is ignored. Nothing is stored, the free count does not drop, and the data is never delivered.
- R7: A read strobe while empty is ignored. The available count does not drop, and no extra credit returns to the write side.
- R8: Status is pessimistic. After a read taken while full, full stays high in the next write cycle. After a write into an empty FIFO, empty stays high in the next read cycle.
- R9: When a counter receives a local decrement and a returning credit in the same cycle, it keeps its value.
- R10: Words leave in the order they were accepted. While empty is low and no read is taken, rdData holds the oldest word. Addresses wrap at DEPTH, which must be a power of two.
- R11: With strobes spaced at least two destination-clock periods apart, every accepted strobe returns exactly one credit. The two counters therefore settle back to DEPTH and 0 once both sides go idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wrClk | input | 1 | Write domain clock |
| wrRstN | input | 1 | Write domain asynchronous reset, active low |
| wrStrobe | input | 1 | Single-cycle write request |
| wrData | input | WIDTH | Word to store |
| full | output | 1 | No free slot as seen by the writer |
| wrFree | output | $clog2(DEPTH+1) | Slots the writer may still fill |
| rdClk | input | 1 | Read domain clock |
| rdRstN | input | 1 | Read domain asynchronous reset, active low |
| rdStrobe | input | 1 | Single-cycle read request, retires the head word |
| rdData | output | WIDTH | Oldest stored word (valid while empty is low) |
| empty | output | 1 | No word available as seen by the reader |
| rdAvail | output | $clog2(DEPTH+1) | Words the reader may take |

## Verification
Two events can land in the same cycle on either counter: the local strobe's decrement and a credit returned by the synchronizer from the other side. Concurrent streaming provokes this coincidence. A writer and a reader run at once on clocks of 10 ns and 14 ns with unrelated phase, and the FIFO fills and drains repeatedly, so credits keep arriving while local strobes are taken. The run is judged in two ways. A scoreboard checks every word in order. After both sides go idle, the counters must have settled exactly back to DEPTH and 0, which would not happen if a coincident update were lost or applied twice.

// File: rtl/cfifo_pkg.sv
package cfifo_pkg;

  // Strobes from the control to the storage: push in the write domain, pop in the read domain.
  typedef struct packed {
    logic push;
    logic pop;
  } memStrobe_t;

endpackage

// File: rtl/cfifo_pulse_xing.sv
// Carries a single-cycle pulse into another clock domain by way of a toggle.
module cfifo_pulse_xing #(
  parameter int SYNC_STAGES = 2
) (
  input  logic srcClk,
  input  logic srcRstN,
  input  logic srcPulse,
  input  logic dstClk,
  input  logic dstRstN,
  output logic dstPulse
);

  logic srcToggle;
  logic [SYNC_STAGES-1:0] syncChain;
  logic lastLevel;

  always_ff @(posedge srcClk or negedge srcRstN) begin
    if (!srcRstN)      srcToggle <= 1'b0;
    else if (srcPulse) srcToggle <= ~srcToggle;
  end

  always_ff @(posedge dstClk or negedge dstRstN) begin
    if (!dstRstN) begin
      syncChain <= '0;
      lastLevel <= 1'b0;
    end else begin
      syncChain <= {syncChain[SYNC_STAGES-2:0], srcToggle};
      lastLevel <= syncChain[SYNC_STAGES-1];
    end
  end

  assign dstPulse = syncChain[SYNC_STAGES-1] ^ lastLevel;

endmodule

// File: rtl/cfifo_credit_ctr.sv
// Occupancy counter: a local take lowers it and a returned credit raises it; both together hold it.
module cfifo_credit_ctr #(
  parameter int                 COUNT_W = 4,
  parameter logic [COUNT_W-1:0] INIT    = '0
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               take,
  input  logic               giveBack,
  output logic [COUNT_W-1:0] count
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) count <= INIT;
    else begin
      unique case ({take, giveBack})
        2'b10:   count <= count - 1'b1;
        2'b01:   count <= count + 1'b1;
        default: count <= count;
      endcase
    end
  end

endmodule

// File: rtl/cfifo_ctrl.sv
module cfifo_ctrl
  import cfifo_pkg::*;
#(
  parameter int DEPTH       = 8,
  parameter int SYNC_STAGES = 2,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          wrClk,
  input  logic          wrRstN,
  input  logic          wrStrobe,
  output logic          full,
  output logic [CW-1:0] wrFree,
  input  logic          rdClk,
  input  logic          rdRstN,
  input  logic          rdStrobe,
  output logic          empty,
  output logic [CW-1:0] rdAvail,
  output memStrobe_t    memCtl
);

  logic wrTake, rdTake;
  logic wrCredit, rdCredit;

  assign full   = (wrFree == '0);
  assign empty  = (rdAvail == '0);
  assign wrTake = wrStrobe & ~full;
  assign rdTake = rdStrobe & ~empty;

  assign memCtl.push = wrTake;
  assign memCtl.pop  = rdTake;

  // Accepted writes travel to the reader.
  cfifo_pulse_xing #(.SYNC_STAGES(SYNC_STAGES)) u_wrToRd (
    .srcClk(wrClk), .srcRstN(wrRstN), .srcPulse(wrTake),
    .dstClk(rdClk), .dstRstN(rdRstN), .dstPulse(rdCredit)
  );

  // Accepted reads travel back to the writer.
  cfifo_pulse_xing #(.SYNC_STAGES(SYNC_STAGES)) u_rdToWr (
    .srcClk(rdClk), .srcRstN(rdRstN), .srcPulse(rdTake),
    .dstClk(wrClk), .dstRstN(wrRstN), .dstPulse(wrCredit)
  );

  cfifo_credit_ctr #(.COUNT_W(CW), .INIT(CW'(DEPTH))) u_freeCtr (
    .clk(wrClk), .rstN(wrRstN), .take(wrTake), .giveBack(wrCredit), .count(wrFree)
  );

  cfifo_credit_ctr #(.COUNT_W(CW), .INIT('0)) u_availCtr (
    .clk(rdClk), .rstN(rdRstN), .take(rdTake), .giveBack(rdCredit), .count(rdAvail)
  );

endmodule

// File: rtl/cfifo_datapath.sv
module cfifo_datapath
  import cfifo_pkg::*;
#(
  parameter int WIDTH = 16,
  parameter int DEPTH = 8,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             wrClk,
  input  logic             wrRstN,
  input  logic             rdClk,
  input  logic             rdRstN,
  input  memStrobe_t       memCtl,
  input  logic [WIDTH-1:0] wrData,
  output logic [WIDTH-1:0] rdData
);

  logic [WIDTH-1:0] slots [DEPTH];
  logic [AW-1:0]    wrAddr, rdAddr;

  always_ff @(posedge wrClk) begin
    if (memCtl.push) slots[wrAddr] <= wrData;
  end

  // Power-of-two depth: the natural binary rollover is the wrap.
  always_ff @(posedge wrClk or negedge wrRstN) begin
    if (!wrRstN)          wrAddr <= '0;
    else if (memCtl.push) wrAddr <= wrAddr + 1'b1;
  end

  always_ff @(posedge rdClk or negedge rdRstN) begin
    if (!rdRstN)         rdAddr <= '0;
    else if (memCtl.pop) rdAddr <= rdAddr + 1'b1;
  end

  assign rdData = slots[rdAddr];

endmodule

// File: rtl/credit_xclk_fifo.sv
module credit_xclk_fifo
  import cfifo_pkg::*;
#(
  parameter int WIDTH       = 16,
  parameter int DEPTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                       wrClk,
  input  logic                       wrRstN,
  input  logic                       wrStrobe,
  input  logic [WIDTH-1:0]           wrData,
  output logic                       full,
  output logic [$clog2(DEPTH+1)-1:0] wrFree,
  input  logic                       rdClk,
  input  logic                       rdRstN,
  input  logic                       rdStrobe,
  output logic [WIDTH-1:0]           rdData,
  output logic                       empty,
  output logic [$clog2(DEPTH+1)-1:0] rdAvail
);

  memStrobe_t memCtl;

  cfifo_ctrl #(.DEPTH(DEPTH), .SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .wrClk(wrClk), .wrRstN(wrRstN), .wrStrobe(wrStrobe), .full(full), .wrFree(wrFree),
    .rdClk(rdClk), .rdRstN(rdRstN), .rdStrobe(rdStrobe), .empty(empty), .rdAvail(rdAvail),
    .memCtl(memCtl)
  );

  cfifo_datapath #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_data (
    .wrClk(wrClk), .wrRstN(wrRstN), .rdClk(rdClk), .rdRstN(rdRstN),
    .memCtl(memCtl), .wrData(wrData), .rdData(rdData)
  );

endmodule

// File: rtl/cfifo_checker.sv
module cfifo_checker #(
  parameter int WIDTH = 16,
  parameter int DEPTH = 8,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic             wrClk,
  input logic             wrRstN,
  input logic             wrStrobe,
  input logic             full,
  input logic [CW-1:0]    wrFree,
  input logic             rdClk,
  input logic             rdRstN,
  input logic             rdStrobe,
  input logic             empty,
  input logic [CW-1:0]    rdAvail,
  input logic [WIDTH-1:0] rdData
);

  // R1
  free_bound_chk: assert property (@(posedge wrClk) disable iff (!wrRstN)
    wrFree <= CW'(DEPTH));

  // R1
  avail_bound_chk: assert property (@(posedge rdClk) disable iff (!rdRstN)
    rdAvail <= CW'(DEPTH));

  // R2
  write_take_chk: assert property (@(posedge wrClk) disable iff (!wrRstN)
    (wrStrobe && !full) |=> (wrFree <= $past(wrFree)));

  // R2
  free_rise_only_chk: assert property (@(posedge wrClk) disable iff (!wrRstN)
    !wrStrobe |=> (wrFree >= $past(wrFree)));

  // R3
  read_take_chk: assert property (@(posedge rdClk) disable iff (!rdRstN)
    (rdStrobe && !empty) |=> (rdAvail <= $past(rdAvail)));

  // R4
  full_rise_chk: assert property (@(posedge wrClk) disable iff (!wrRstN)
    $rose(full) |-> $past(wrStrobe));

  // R5
  empty_rise_chk: assert property (@(posedge rdClk) disable iff (!rdRstN)
    $rose(empty) |-> $past(rdStrobe));

  // R6
  no_overflow_chk: assert property (@(posedge wrClk) disable iff (!wrRstN)
    (wrStrobe && full) |=> (wrFree >= $past(wrFree)));

  // R7
  no_underflow_chk: assert property (@(posedge rdClk) disable iff (!rdRstN)
    (rdStrobe && empty) |=> (rdAvail >= $past(rdAvail)));

  // R10
  head_hold_chk: assert property (@(posedge rdClk) disable iff (!rdRstN)
    (!empty && !rdStrobe) |=> $stable(rdData));

endmodule

bind credit_xclk_fifo cfifo_checker #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_checker (
  .wrClk(wrClk), .wrRstN(wrRstN), .wrStrobe(wrStrobe), .full(full), .wrFree(wrFree),
  .rdClk(rdClk), .rdRstN(rdRstN), .rdStrobe(rdStrobe), .empty(empty), .rdAvail(rdAvail),
  .rdData(rdData)
);

// File: tb/credit_xclk_fifo_bench.sv
`timescale 1ns/1ps
module credit_xclk_fifo_bench;

  localparam int WIDTH = 16;
  localparam int DEPTH = 8;
  localparam int CW    = $clog2(DEPTH + 1);

  logic             wrClk = 1'b0, rdClk = 1'b0;
  logic             wrRstN = 1'b0, rdRstN = 1'b0;
  logic             wrStrobe = 1'b0, rdStrobe = 1'b0;
  logic [WIDTH-1:0] wrData = '0;
  logic             full, empty;
  logic [CW-1:0]    wrFree, rdAvail;
  logic [WIDTH-1:0] rdData;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  logic [WIDTH-1:0] expQ[$];

  always #5 wrClk = ~wrClk;   // 100 MHz write clock
  always #7 rdClk = ~rdClk;   // unrelated read clock

  credit_xclk_fifo #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_credit_xclk_fifo (
    .wrClk(wrClk), .wrRstN(wrRstN), .wrStrobe(wrStrobe), .wrData(wrData),
    .full(full), .wrFree(wrFree),
    .rdClk(rdClk), .rdRstN(rdRstN), .rdStrobe(rdStrobe), .rdData(rdData),
    .empty(empty), .rdAvail(rdAvail)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Driver: one write strobe, spaced three write cycles from the next.
  task automatic doWrite(input logic [WIDTH-1:0] d, output bit took);
    @(negedge wrClk);
    took = !full;
    if (took) expQ.push_back(d);
    wrData   = d;
    wrStrobe = 1'b1;
    @(negedge wrClk);
    wrStrobe = 1'b0;
    @(negedge wrClk);
  endtask

  // Monitor: pops the scoreboard and compares the head word, then strobes.
  task automatic doRead(output bit took);
    logic [WIDTH-1:0] exp;
    @(negedge rdClk);
    took = !empty;
    if (took) begin
      if (expQ.size() == 0) check(1'b0, "R10", int'(rdData), -1);
      else begin
        exp = expQ.pop_front();
        check(rdData == exp, "R10", int'(rdData), int'(exp));
      end
    end
    rdStrobe = 1'b1;
    @(negedge rdClk);
    rdStrobe = 1'b0;
    @(negedge rdClk);
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    bit took;
    logic [WIDTH-1:0] exp;

    repeat (3) @(negedge wrClk);
    // R1 reset state
    check(wrFree == CW'(DEPTH), "R1", int'(wrFree), DEPTH);
    check(full == 1'b0, "R1", int'(full), 0);
    check(rdAvail == '0, "R1", int'(rdAvail), 0);
    check(empty == 1'b1, "R1", int'(empty), 1);
    wrRstN = 1'b1;
    rdRstN = 1'b1;
    repeat (3) @(negedge wrClk);

    // First write: immediate local decrement (R2), reader still sees empty (R8)
    @(negedge wrClk);
    expQ.push_back(16'h1000);
    wrData = 16'h1000;
    wrStrobe = 1'b1;
    @(posedge wrClk);
    #2 wrStrobe = 1'b0;
    @(negedge rdClk);
    check(empty == 1'b1, "R8", int'(empty), 1);
    @(negedge wrClk);
    check(wrFree == CW'(DEPTH - 1), "R2", int'(wrFree), DEPTH - 1);
    @(negedge wrClk);

    // Fill to one free slot, then consume it: full appears at once (R4)
    for (int i = 1; i < DEPTH - 1; i++) doWrite(WIDTH'(16'h1000 + i), took);
    check(wrFree == 1 && !full, "R4", int'(wrFree), 1);
    @(negedge wrClk);
    expQ.push_back(16'h10FF);
    wrData = 16'h10FF;
    wrStrobe = 1'b1;
    @(negedge wrClk);
    wrStrobe = 1'b0;
    check(full == 1'b1, "R4", int'(full), 1);
    check(wrFree == '0, "R4", int'(wrFree), 0);

    // Credits reach the reader (R2, R11)
    repeat (8) @(negedge rdClk);
    check(rdAvail == CW'(DEPTH), "R2", int'(rdAvail), DEPTH);
    check(empty == 1'b0, "R5", int'(empty), 0);

    // Write while full is dropped (R6)
    doWrite(16'hDEAD, took);
    check(took == 1'b0, "R6", int'(took), 0);
    repeat (3) @(negedge wrClk);
    check(wrFree == '0, "R6", int'(wrFree), 0);

    // One read while full: full stays set in the next write cycle (R8), then clears (R3)
    @(negedge rdClk);
    exp = expQ.pop_front();
    check(rdData == exp, "R10", int'(rdData), int'(exp));
    rdStrobe = 1'b1;
    @(posedge rdClk);
    #2 rdStrobe = 1'b0;
    @(negedge wrClk);
    check(full == 1'b1, "R8", int'(full), 1);
    @(negedge rdClk);
    check(rdAvail == CW'(DEPTH - 1), "R3", int'(rdAvail), DEPTH - 1);
    repeat (6) @(negedge wrClk);
    check(wrFree == 1 && !full, "R3", int'(wrFree), 1);

    // Drain down to one, then take the last word: empty appears at once (R5)
    for (int i = 0; i < DEPTH - 2; i++) doRead(took);
    @(negedge rdClk);
    check(rdAvail == 1, "R5", int'(rdAvail), 1);
    exp = expQ.pop_front();
    check(rdData == exp, "R10", int'(rdData), int'(exp));
    rdStrobe = 1'b1;
    @(negedge rdClk);
    rdStrobe = 1'b0;
    check(empty == 1'b1, "R5", int'(empty), 1);
    check(rdAvail == '0, "R5", int'(rdAvail), 0);

    // Read while empty is ignored (R7)
    doRead(took);
    check(took == 1'b0, "R7", int'(took), 0);
    repeat (3) @(negedge rdClk);
    check(rdAvail == '0, "R7", int'(rdAvail), 0);
    repeat (8) @(negedge wrClk);
    check(wrFree == CW'(DEPTH), "R7", int'(wrFree), DEPTH);
    check(expQ.size() == 0, "R6", expQ.size(), 0);

    // Concurrent streaming with wrap-around: coincident take and credit (R9, R10, R11)
    fork
      begin
        int accepted = 0;
        int n = 0;
        while (accepted < 40) begin
          doWrite(WIDTH'(n * 37 + 5), took);
          if (took) accepted++;
          n++;
        end
      end
      begin
        int got = 0;
        bit t;
        while (got < 40) begin
          doRead(t);
          if (t) got++;
        end
      end
    join
    repeat (10) @(negedge wrClk);
    check(wrFree == CW'(DEPTH), "R9", int'(wrFree), DEPTH);
    check(rdAvail == '0, "R11", int'(rdAvail), 0);
    check(empty && !full, "R11", int'({empty, full}), 2);
    check(expQ.size() == 0, "R11", expQ.size(), 0);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule